// File: doc/BRIEF.md
# Clock Gating Power Manager

This block decides which clocks in a small processor subsystem run. It drives one gate enable for the processor core clock and one gate enable per peripheral. Software sets and clears the gates through a plain register bus. Each clock group has a write-one-to-set register, a write-one-to-clear register and a read-only status register. The glitch-free clock cells sit outside the block and take the enables as their control inputs.

Peripheral gates open or close on the clock edge that takes the write. When a gate reopens, the peripheral keeps all of its state. The core gate works differently, because the core must not stop partway through an instruction. A disable request waits until the core raises its instruction-done handshake. If an interrupt that the interrupt controller has unmasked is pending, the core gate opens again without software action.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset `core_clk_en` is 1 and every bit of `periph_clk_en` is 0. A read of the core status offset 0x08 returns 0x1 and a read of the peripheral status offset 0x18 returns 0x0.
- R2: A write to offset 0x10 sets bit n of `periph_clk_en` on the next clock edge for every data bit n that is 1. A data bit of 0 leaves the matching enable unchanged.
- R3: A write to offset 0x14 clears bit n of `periph_clk_en` on the next clock edge for every data bit n that is 1. The other bits are unchanged. There is no wait for any handshake.
- R4: A read of offset 0x18 returns the current `periph_clk_en` value in bits [NUM_PERIPH-1:0]. Bit n of every peripheral register stands for interrupt source n.
- R5: A write to offset 0x04 with data bit 0 set, made while no enabled interrupt is pending, starts a shutdown. `core_clk_en` stays 1 until a clock edge at which `cpu_done` is 1, and it is 0 from that edge on.
- R6: A shutdown still waiting for `cpu_done` is cancelled by a write to offset 0x00 with data bit 0 set, or by a pending enabled interrupt. After that, `cpu_done` does not close the gate.
- R7: While the core gate is closed, any bit set in both `irq_pending` and `irq_enable` reopens it on the next clock edge. A pending interrupt whose enable bit is 0 has no effect.
- R8: While the core gate is closed, a write to offset 0x00 with data bit 0 set reopens it on the next clock edge. The same write with bit 0 clear has no effect.
- R9: Reads of offsets 0x00, 0x04, 0x0C, 0x10 and 0x14 return 0. Writes to 0x08, 0x0C and 0x18 change no gate.
- R10: A read of offset 0x08 returns `core_clk_en` in bit 0, with 0 in all other bits.
- R11: Writes to the core offsets and any change of the core gate leave `periph_clk_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that is never gated |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, valid for one cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while a read is selected, 0 otherwise |
| cpu_done | input | 1 | Core reports that its current instruction has finished |
| irq_pending | input | NUM_PERIPH | Pending interrupt sources |
| irq_enable | input | NUM_PERIPH | Interrupt mask from the interrupt controller, 1 means enabled |
| core_clk_en | output | 1 | Gate enable for the core clock |
| periph_clk_en | output | NUM_PERIPH | Gate enable for each peripheral clock |

## Verification
The assertions assume that only one register access arrives per cycle and that `bus_wdata` holds steady while `bus_sel` is high. The bench drives every access from a task that raises `bus_sel` for exactly one cycle, so both assumptions always hold. The shutdown check assumes that `cpu_done` means the instruction has finished whenever it is sampled. The bench raises it only at a negative clock edge and holds it for whole cycles, so the sampling is never ambiguous. Interrupt inputs change only at negative edges, so the wake assertion always sees them one full cycle before the edge it checks.

// File: rtl/pgc_pkg.sv
// Package: shared offsets and types for the clock gating power manager.
// Assumes: register offsets fit in 8 bits and the bus word is 32 bits wide.
package pgc_pkg;

    localparam int unsigned BUS_W = 32;

    // Byte offsets of the registers. Each enable, disable and status group
    // is decoded as a unit.
    localparam logic [7:0] OFF_CORE_SET  = 8'h00;
    localparam logic [7:0] OFF_CORE_CLR  = 8'h04;
    localparam logic [7:0] OFF_CORE_STAT = 8'h08;
    localparam logic [7:0] OFF_PER_SET   = 8'h10;
    localparam logic [7:0] OFF_PER_CLR   = 8'h14;
    localparam logic [7:0] OFF_PER_STAT  = 8'h18;

    // Write strobes decoded from one bus cycle.
    typedef struct packed {
        logic core_set;
        logic core_clr;
        logic per_set;
        logic per_clr;
    } pgc_wr_t;

    // States of the core clock gate.
    typedef enum logic [1:0] {
        CG_RUN   = 2'd0,
        CG_DRAIN = 2'd1,
        CG_OFF   = 2'd2
    } cg_state_t;

endpackage

// File: rtl/pgc_regif.sv
// Module: pgc_regif
// Decodes register bus accesses into write strobes and builds the read data.
// Assumes: at most one access per cycle, and ADDR_W of at least 8 bits.
// Write-only and reserved offsets read as zero.
module pgc_regif
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_PERIPH = 32
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic                  core_on,
    input  logic [NUM_PERIPH-1:0] per_state,
    output pgc_wr_t               wr,
    output logic [BUS_W-1:0]      bus_rdata
);

    localparam int unsigned PAD_W = BUS_W - NUM_PERIPH;

    logic wr_cyc;
    logic rd_cyc;

    assign wr_cyc = bus_sel && bus_wr;
    assign rd_cyc = bus_sel && !bus_wr;

    // Write strobe decode. The core strobes carry only data bit 0.
    always_comb begin
        wr.core_set = wr_cyc && (bus_addr == ADDR_W'(OFF_CORE_SET)) && bus_wdata[0];
        wr.core_clr = wr_cyc && (bus_addr == ADDR_W'(OFF_CORE_CLR)) && bus_wdata[0];
        wr.per_set  = wr_cyc && (bus_addr == ADDR_W'(OFF_PER_SET));
        wr.per_clr  = wr_cyc && (bus_addr == ADDR_W'(OFF_PER_CLR));
    end

    // Read data multiplexer for the two status registers. Every other offset reads 0.
    generate
        if (PAD_W == 0) begin : g_full
            always_comb begin
                bus_rdata = '0;
                if (rd_cyc && bus_addr == ADDR_W'(OFF_CORE_STAT))
                    bus_rdata = {{(BUS_W-1){1'b0}}, core_on};
                else if (rd_cyc && bus_addr == ADDR_W'(OFF_PER_STAT))
                    bus_rdata = per_state;
            end
        end else begin : g_pad
            always_comb begin
                bus_rdata = '0;
                if (rd_cyc && bus_addr == ADDR_W'(OFF_CORE_STAT))
                    bus_rdata = {{(BUS_W-1){1'b0}}, core_on};
                else if (rd_cyc && bus_addr == ADDR_W'(OFF_PER_STAT))
                    bus_rdata = {{PAD_W{1'b0}}, per_state};
            end
        end
    endgenerate

endmodule

// File: rtl/pgc_core_gate.sv
// Module: pgc_core_gate
// Controls the core clock gate with a three-state machine.
// Assumes: cpu_done is synchronous to clk, and the interrupt inputs are
// synchronous levels. A disable request moves to DRAIN and waits there for
// cpu_done. A set write or a pending enabled interrupt goes back to RUN.
module pgc_core_gate
    import pgc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_req,
    input  logic               clr_req,
    input  logic               cpu_done,
    input  logic [NUM_IRQ-1:0] irq_pending,
    input  logic [NUM_IRQ-1:0] irq_enable,
    output logic               core_on
);

    cg_state_t state_q;
    cg_state_t state_d;
    logic      wake;

    // Wake condition: at least one interrupt that is both pending and unmasked.
    assign wake = |(irq_pending & irq_enable);

    // Next-state logic. A wake or a set request always wins over shutdown.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CG_RUN:   if (clr_req && !wake)   state_d = CG_DRAIN;
            CG_DRAIN: if (set_req || wake)    state_d = CG_RUN;
                      else if (cpu_done)      state_d = CG_OFF;
            CG_OFF:   if (set_req || wake)    state_d = CG_RUN;
            default:                          state_d = CG_RUN;
        endcase
    end

    // State register. Reset leaves the core clock running.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CG_RUN;
        else        state_q <= state_d;
    end

    // The gate stays open in every state except OFF.
    assign core_on = (state_q != CG_OFF);

endmodule

// File: rtl/pgc_periph_bank.sv
// Module: pgc_periph_bank
// Holds one set/clear gate flop per peripheral.
// Assumes: set and clear come from different offsets, so they are never both
// active in one cycle. If they were, clear would win. Bit n stands for
// interrupt source n. Gating never resets peripheral state.
module pgc_periph_bank #(
    parameter int unsigned NUM_PERIPH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_stb,
    input  logic                  clr_stb,
    input  logic [NUM_PERIPH-1:0] wmask,
    output logic [NUM_PERIPH-1:0] gate_en
);

    generate
        for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_bit
            logic en_q;

            // Per-bit gate flop: clear beats set, and reset closes the gate.
            always_ff @(posedge clk) begin
                if (!rst_n)                   en_q <= 1'b0;
                else if (clr_stb && wmask[n]) en_q <= 1'b0;
                else if (set_stb && wmask[n]) en_q <= 1'b1;
            end

            assign gate_en[n] = en_q;
        end
    endgenerate

endmodule

// File: rtl/pwr_gate_ctrl.sv
// Module: pwr_gate_ctrl (top)
// Clock gating power manager: one core clock gate with a completion handshake
// and interrupt wake, plus NUM_PERIPH peripheral gates that act at once.
// Assumes: NUM_PERIPH is between 1 and 32, ADDR_W is at least 8, and the
// enable outputs feed glitch-free gating cells outside this block.
module pwr_gate_ctrl
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_PERIPH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  cpu_done,
    input  logic [NUM_PERIPH-1:0] irq_pending,
    input  logic [NUM_PERIPH-1:0] irq_enable,
    output logic                  core_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en
);

    pgc_wr_t wr;

    pgc_regif #(.ADDR_W(ADDR_W), .NUM_PERIPH(NUM_PERIPH)) u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .core_on   (core_clk_en),
        .per_state (periph_clk_en),
        .wr        (wr),
        .bus_rdata (bus_rdata)
    );

    pgc_core_gate #(.NUM_IRQ(NUM_PERIPH)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (wr.core_set),
        .clr_req     (wr.core_clr),
        .cpu_done    (cpu_done),
        .irq_pending (irq_pending),
        .irq_enable  (irq_enable),
        .core_on     (core_clk_en)
    );

    pgc_periph_bank #(.NUM_PERIPH(NUM_PERIPH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr.per_set),
        .clr_stb (wr.per_clr),
        .wmask   (bus_wdata[NUM_PERIPH-1:0]),
        .gate_en (periph_clk_en)
    );

endmodule

// File: rtl/pgc_checker.sv
// Module: pgc_checker
// Temporal properties of the power manager, observed at its ports only.
// Assumes: a single access per cycle, with its data held while it is selected.
module pgc_checker
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_PERIPH = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic                  cpu_done,
    input logic [NUM_PERIPH-1:0] irq_pending,
    input logic [NUM_PERIPH-1:0] irq_enable,
    input logic                  core_clk_en,
    input logic [NUM_PERIPH-1:0] periph_clk_en
);

    logic                  per_set_w;
    logic                  per_clr_w;
    logic                  core_w;
    logic                  wake_in;
    logic [NUM_PERIPH-1:0] mask;

    assign mask      = bus_wdata[NUM_PERIPH-1:0];
    assign per_set_w = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_PER_SET);
    assign per_clr_w = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_PER_CLR);
    assign core_w    = bus_sel && bus_wr &&
                       (bus_addr == ADDR_W'(OFF_CORE_SET) || bus_addr == ADDR_W'(OFF_CORE_CLR));
    assign wake_in   = |(irq_pending & irq_enable);

    // R2: every bit written as 1 to the set offset is open one edge later.
    assert_per_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        per_set_w |=> ((periph_clk_en & $past(mask)) == $past(mask)));

    // R3: every bit written as 1 to the clear offset is closed one edge later.
    assert_per_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_clr_w |=> ((periph_clk_en & $past(mask)) == '0));

    // R5: the core gate closes only at an edge where the core reported done.
    assert_core_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(cpu_done));

    // R7: a pending enabled interrupt reopens a closed core gate.
    assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && wake_in) |=> core_clk_en);

    // R11: writes to the core offsets leave the peripheral gates unchanged.
    assert_core_iso_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_w |=> $stable(periph_clk_en));

endmodule

bind pwr_gate_ctrl pgc_checker #(.ADDR_W(ADDR_W), .NUM_PERIPH(NUM_PERIPH)) u_pgc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .cpu_done      (cpu_done),
    .irq_pending   (irq_pending),
    .irq_enable    (irq_enable),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en)
);

// File: tb/test_pwr_gate_ctrl.sv
`timescale 1ns/1ps
// Bench for pwr_gate_ctrl. A table of peripheral write vectors is walked by
// one loop, then directed tests cover reset, the core handshake, wake and
// cancel paths. Inputs change at the negative edge. Outputs are sampled 1 ns
// after the positive edge.
module test_pwr_gate_ctrl;

    localparam int unsigned AW = 8;
    localparam int unsigned NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cpu_done = 1'b0;
    logic [NP-1:0] irq_pending = '0;
    logic [NP-1:0] irq_enable = '0;
    logic          core_clk_en;
    logic [NP-1:0] periph_clk_en;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    pwr_gate_ctrl #(.ADDR_W(AW), .NUM_PERIPH(NP)) i_pwr_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_done(cpu_done), .irq_pending(irq_pending), .irq_enable(irq_enable),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h10, 32'h0000_00F0, 32'h0000_00F0},  // R2 set
        '{8'h10, 32'h0000_0000, 32'h0000_00F0},  // R2 zero bits do nothing
        '{8'h10, 32'h8000_0001, 32'h8000_00F1},  // R2 both edge bits
        '{8'h14, 32'h0000_0030, 32'h8000_00C1},  // R3 clear subset
        '{8'h14, 32'h0000_0000, 32'h8000_00C1},  // R3 zero bits do nothing
        '{8'h10, 32'h0000_0030, 32'h8000_00F1},  // R2 re-enable
        '{8'h14, 32'h8000_0000, 32'h0000_00F1},  // R3 top bit
        '{8'h14, 32'hFFFF_FFFF, 32'h0000_0000},  // R3 all
        '{8'h10, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R2 pattern
        '{8'h08, 32'hFFFF_FFFF, 32'hA5A5_A5A5},  // R9 status write
        '{8'h18, 32'h0000_0000, 32'hA5A5_A5A5},  // R9 status write
        '{8'h0C, 32'hFFFF_FFFF, 32'hA5A5_A5A5}   // R9 reserved write
    };

    // Compares one value and records a failure with both values.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Performs one write cycle and samples 1 ns after the edge that takes it.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Performs a combinational read during the low phase of the clock.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Moves cpu_done to a new level at a negative edge, then waits one edge.
    task automatic step_done(input logic v);
        @(negedge clk); cpu_done = v;
        @(posedge clk); #1;
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state at the ports and in the status registers.
        check("R1 core gate", {31'b0, core_clk_en}, 32'h1);
        check("R1 periph gates", periph_clk_en, 32'h0);
        bus_read(8'h08, rd); check("R1 core status", rd, 32'h1);
        bus_read(8'h18, rd); check("R1 periph status", rd, 32'h0);

        // R2 R3 R9 R4: walk the vector table.
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].addr, VEC[i].data);
            check($sformatf("R2/R3/R9 vec%0d gates", i), periph_clk_en, VEC[i].exp);
            bus_read(8'h18, rd);
            check($sformatf("R4 vec%0d status", i), rd, VEC[i].exp);
        end
        check("R9 core untouched", {31'b0, core_clk_en}, 32'h1);

        // R9: write-only and reserved offsets read 0.
        bus_read(8'h00, rd); check("R9 read 0x00", rd, 32'h0);
        bus_read(8'h04, rd); check("R9 read 0x04", rd, 32'h0);
        bus_read(8'h0C, rd); check("R9 read 0x0C", rd, 32'h0);
        bus_read(8'h10, rd); check("R9 read 0x10", rd, 32'h0);
        bus_read(8'h14, rd); check("R9 read 0x14", rd, 32'h0);

        // R5: disable waits for the handshake.
        bus_write(8'h04, 32'h1);
        repeat (3) @(posedge clk);
        #1 check("R5 held open", {31'b0, core_clk_en}, 32'h1);
        bus_read(8'h08, rd); check("R10 status while draining", rd, 32'h1);
        step_done(1'b1);
        check("R5 closed after done", {31'b0, core_clk_en}, 32'h0);
        step_done(1'b0);
        bus_read(8'h08, rd); check("R10 status closed", rd, 32'h0);
        check("R11 periph kept", periph_clk_en, 32'hA5A5_A5A5);

        // R7: a masked interrupt does nothing, an enabled one wakes the core.
        @(negedge clk); irq_enable = 32'h0000_0008; irq_pending = 32'h0000_0020;
        @(posedge clk); #1;
        check("R7 masked irq ignored", {31'b0, core_clk_en}, 32'h0);
        @(negedge clk); irq_pending = 32'h0000_0028;
        @(posedge clk); #1;
        check("R7 enabled irq wakes", {31'b0, core_clk_en}, 32'h1);
        @(negedge clk); irq_pending = '0;

        // R6: a set write cancels a pending shutdown.
        bus_write(8'h04, 32'h1);
        bus_write(8'h00, 32'h1);
        step_done(1'b1); step_done(1'b0);
        check("R6 cancel by set write", {31'b0, core_clk_en}, 32'h1);

        // R6: a wake during drain cancels the shutdown.
        bus_write(8'h04, 32'h1);
        @(negedge clk); irq_pending = 32'h0000_0008;
        @(posedge clk); #1;
        @(negedge clk); irq_pending = '0;
        step_done(1'b1); step_done(1'b0);
        check("R6 cancel by wake", {31'b0, core_clk_en}, 32'h1);

        // R8: with the gate closed, bit 0 clear does nothing and bit 0 set reopens it.
        bus_write(8'h04, 32'h1);
        step_done(1'b1); step_done(1'b0);
        check("R8 closed", {31'b0, core_clk_en}, 32'h0);
        bus_write(8'h00, 32'hFFFF_FFFE);
        check("R8 zero bit ignored", {31'b0, core_clk_en}, 32'h0);
        bus_write(8'h00, 32'h1);
        check("R8 set reopens", {31'b0, core_clk_en}, 32'h1);
        check("R11 periph after core traffic", periph_clk_en, 32'hA5A5_A5A5);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule